// File: doc/BRIEF.md
# Serial Bus Control Byte Matcher

This block decides whether the first byte after a Start condition on a two-wire serial bus is addressed to this device. The upper four bits of that byte carry a device code. The block builds its own expected code one bit at a time. For each bit, a select input chooses between a stored configuration bit and a live board pin, so a board can strap part of the address with pins and keep the rest in configuration. The pins pass through a synchroniser before they are used.

When the codes are equal, the block asks the bus interface to acknowledge. It also captures the three block-address bits and the transfer direction, and holds them for the data phase that follows. These three bits become the top bits of the memory address. When the codes differ, the block stays silent and ignores all traffic until the next Start. The bit-level bus engine sits outside this block. It supplies the assembled byte with a one-cycle valid strobe, and it supplies one-cycle Start and Stop pulses.

Top module: `ctl_byte_match`

## Requirements
- R1: The received byte is split as follows. Bits 7:4 are the device code. Bits 3:1 are block address bits A10, A9 and A8, with bit 3 as A10, and they appear on `blk_addr_o[2:0]` in that order. Bit 0 is the direction, where 1 is a read and 0 is a write, and it appears on `rd_o`.
- R2: Expected code bit i is taken from `pin_i[i]` when `src_sel_i[i]` is 1, and from `reg_code_i[i]` when `src_sel_i[i]` is 0. Pin 0 feeds the code LSB and pin 3 feeds the code MSB.
- R3: Pin levels pass through two synchroniser flops. A pin change applied in the same cycle as the byte strobe is not yet seen by the comparison. A pin level held for three or more cycles is seen.
- R4: When the first byte after a Start matches, `ack_o` is high for exactly one cycle, in the cycle after the byte strobe.
- R5: When the first byte after a Start does not match, no acknowledge is given. All later bytes are ignored, with no acknowledge, until the next Start.
- R6: After a match, `matched_o` is high and `blk_addr_o` and `rd_o` hold the captured values until a Start or a Stop. In the cycle after that Start or Stop, `matched_o`, `blk_addr_o` and `rd_o` all read 0.
- R7: After a match, further bytes give no acknowledge and leave `blk_addr_o`, `rd_o` and `matched_o` unchanged.
- R8: Bytes that arrive after a Stop, or after reset with no Start since, give no acknowledge.
- R9: Stop takes priority over Start in the same cycle, and the block then waits idle. A byte strobe in the same cycle as a Start is discarded. Only the next byte is decoded.
- R10: After reset, `ack_o`, `matched_o`, `blk_addr_o` and `rd_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle pulse: Start condition seen |
| stop_i | input | 1 | One-cycle pulse: Stop condition seen |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` holds a complete received byte |
| byte_i | input | 8 | Received byte |
| pin_i | input | 4 | Asynchronous address strap pins, bit 0 feeds the code LSB |
| reg_code_i | input | 4 | Configured device code (usually 0001 out of reset) |
| src_sel_i | input | 4 | Per-bit code source: 1 selects the pin, 0 selects the register |
| ack_o | output | 1 | One-cycle request to acknowledge the control byte |
| matched_o | output | 1 | Device is addressed in the current transaction |
| blk_addr_o | output | 3 | Captured A10:A8 |
| rd_o | output | 1 | Captured direction, 1 = read |

## Verification
A state register that is stuck or wrongly updated shows up on `ack_o` one cycle after the next byte strobe. The symptom is either a missing acknowledge after a Start or an extra acknowledge on a later byte. A capture register that fails to clear or to hold shows up on `blk_addr_o`, `rd_o` or `matched_o` in the cycle after the Start, Stop or extra byte that should have cleared or kept it. A wrong synchroniser depth or a wrong source mux shows up as an acknowledge decision that differs from the expected one for a byte sent right after a pin change, or for a byte sent with mixed source selects.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIT  = 2'd2,
    ST_SKIP = 2'd3
  } cbm_state_e;
endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cbm_code_sel.sv
module cbm_code_sel #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] pin_sync_i,
  input  logic [CODE_W-1:0] reg_code_i,
  input  logic [CODE_W-1:0] src_sel_i,
  output logic [CODE_W-1:0] code_o
);
  generate
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
      assign code_o[b] = src_sel_i[b] ? pin_sync_i[b] : reg_code_i[b];
    end
  endgenerate
endmodule

// File: rtl/ctl_byte_match.sv
module ctl_byte_match
  import cbm_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int BLK_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = CODE_W + BLK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CODE_W-1:0] pin_i,
  input  logic [CODE_W-1:0] reg_code_i,
  input  logic [CODE_W-1:0] src_sel_i,
  output logic              ack_o,
  output logic              matched_o,
  output logic [BLK_W-1:0]  blk_addr_o,
  output logic              rd_o
);
  logic [CODE_W-1:0] pin_sync;
  logic [CODE_W-1:0] exp_code;
  logic [CODE_W-1:0] rx_code;
  logic [BLK_W-1:0]  rx_blk;
  logic              rx_rd;
  logic              code_eq;

  cbm_state_e st_q, st_d;
  logic       hit;
  logic       clr;
  logic       ack_q;
  logic [BLK_W-1:0] blk_q;
  logic       rd_q;

  cbm_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  cbm_code_sel #(.CODE_W(CODE_W)) u_sel (
    .pin_sync_i (pin_sync),
    .reg_code_i (reg_code_i),
    .src_sel_i  (src_sel_i),
    .code_o     (exp_code)
  );

  assign rx_code = byte_i[BYTE_W-1 -: CODE_W];
  assign rx_blk  = byte_i[BLK_W:1];
  assign rx_rd   = byte_i[0];
  assign code_eq = (rx_code == exp_code);

  // next state: stop beats start, start beats a byte in the same cycle
  always_comb begin
    st_d = st_q;
    hit  = 1'b0;
    clr  = start_i | stop_i;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else if (start_i) begin
      st_d = ST_WAIT;
    end else if (st_q == ST_WAIT && byte_vld_i) begin
      st_d = code_eq ? ST_HIT : ST_SKIP;
      hit  = code_eq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      rd_q  <= 1'b0;
    end else if (clr) begin
      blk_q <= '0;
      rd_q  <= 1'b0;
    end else if (hit) begin
      blk_q <= rx_blk;
      rd_q  <= rx_rd;
    end
  end

  assign ack_o      = ack_q;
  assign matched_o  = (st_q == ST_HIT);
  assign blk_addr_o = blk_q;
  assign rd_o       = rd_q;

  assert_ack_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  assert_ack_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($past(byte_vld_i) && !$past(start_i) && !$past(stop_i)));

  assert_ack_addressed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> matched_o);

  assert_hold_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (matched_o && !start_i && !stop_i) |=>
      (matched_o && !ack_o && $stable(blk_addr_o) && $stable(rd_o)));

  assert_clear_on_bus_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> (!matched_o && !ack_o && blk_addr_o == '0 && !rd_o));

  assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (st_q == ST_IDLE));

  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> !ack_o);

  assert_skip_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP && !start_i) |=> !ack_o);
endmodule

// File: tb/ctl_byte_match_tb.sv
module ctl_byte_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [3:0] pin_i = 4'h0;
  logic [3:0] reg_code_i = 4'b0001;
  logic [3:0] src_sel_i = 4'h0;
  logic       ack_o;
  logic       matched_o;
  logic [2:0] blk_addr_o;
  logic       rd_o;

  int total = 0;
  int bad = 0;
  logic vld_seen = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic       ack;
    logic       matched;
    logic [2:0] blk;
    logic       rd;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ctl_byte_match u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .pin_i(pin_i),
    .reg_code_i(reg_code_i), .src_sel_i(src_sel_i), .ack_o(ack_o),
    .matched_o(matched_o), .blk_addr_o(blk_addr_o), .rd_o(rd_o)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic send(input logic [7:0] b, input logic ack, input logic m,
                      input logic [2:0] blk, input logic rd, input string req);
    exp_t e;
    e.ack = ack; e.matched = m; e.blk = blk; e.rd = rd; e.req = req;
    exp_q.push_back(e);
    byte_i = b;
    byte_vld_i = 1'b1;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) vld_seen <= byte_vld_i;

  // monitor: compares results one cycle after each strobe
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vld_seen) begin
        if (exp_q.size() == 0) begin
          check("scoreboard", 6'd1, 6'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, {ack_o, matched_o, blk_addr_o, rd_o},
                       {e.ack, e.matched, e.blk, e.rd});
        end
      end else if (ack_o) begin
        check("R4 spurious ack", {5'd0, ack_o}, 6'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 6'd1, 6'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    check("R10 reset", {ack_o, matched_o, blk_addr_o, rd_o}, 6'd0);
    rst_n = 1'b1;
    idle(4);

    // R1 R4: match from register code 0001
    pulse_start();
    send(8'h1B, 1, 1, 3'd5, 1, "R1 R4 match read blk5");
    // R7: later byte ignored, capture held
    send(8'hFF, 0, 1, 3'd5, 1, "R7 extra byte held");
    send(8'h1A, 0, 1, 3'd5, 1, "R7 matching byte not redecoded");
    // R6: stop clears
    pulse_stop();
    check("R6 clear after stop", {ack_o, matched_o, blk_addr_o, rd_o}, 6'd0);
    // R8: byte with no start
    send(8'h1B, 0, 0, 3'd0, 0, "R8 byte after stop");

    // R5: mismatch then ignore
    pulse_start();
    send(8'h2B, 0, 0, 3'd0, 0, "R5 mismatch code 2");
    send(8'h1B, 0, 0, 3'd0, 0, "R5 ignored until start");
    // R1: write direction
    pulse_start();
    send(8'h10, 1, 1, 3'd0, 0, "R1 match write blk0");
    pulse_start();
    check("R6 clear after start", {ack_o, matched_o, blk_addr_o, rd_o}, 6'd0);
    send(8'h1E, 1, 1, 3'd7, 0, "R1 repeated start blk7");

    // R2: all bits from pins
    src_sel_i = 4'b1111;
    pin_i = 4'b1010;
    idle(4);
    pulse_start();
    send(8'hA6, 1, 1, 3'd3, 0, "R2 all pins 1010");
    pulse_start();
    send(8'h16, 0, 0, 3'd0, 0, "R2 register code unused");

    // R2: mixed sources, code 1101
    reg_code_i = 4'b1000;
    src_sel_i = 4'b0101;
    pin_i = 4'b0101;
    idle(4);
    pulse_start();
    send(8'hDF, 1, 1, 3'd7, 1, "R2 mixed sources");

    // R3: pin change in the strobe cycle is not yet seen
    src_sel_i = 4'b1111;
    idle(4);
    pulse_start();
    pin_i = 4'b0011;
    send(8'h52, 1, 1, 3'd1, 0, "R3 old pin level used");
    idle(3);
    pulse_start();
    send(8'h35, 1, 1, 3'd2, 1, "R3 new pin level used");
    pulse_stop();

    // R9: stop and start together -> idle
    src_sel_i = 4'b0000;
    reg_code_i = 4'b0001;
    start_i = 1'b1;
    stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    stop_i = 1'b0;
    send(8'h1B, 0, 0, 3'd0, 0, "R9 stop beats start");
    // R9: byte in the start cycle discarded
    start_i = 1'b1;
    send(8'h1B, 0, 0, 3'd0, 0, "R9 byte with start discarded");
    start_i = 1'b0;
    send(8'h19, 1, 1, 3'd4, 1, "R9 next byte decoded");
    idle(3);

    done = 1'b1;
    if (exp_q.size() != 0) check("scoreboard drain", 6'd1, 6'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule